// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four pulse-width-modulated output pins from one clock. Each channel owns a single 32-bit control word that carries a run bit, an 8-bit high-time value and a 13-bit clock divider. The divider slows the input clock down to a tick rate. An 8-bit phase counter advances once per tick, so every output period spans 256 ticks. The pin stays high while the phase is below the high-time value and is low for the rest of the period.

Software programs the channels over a simple bus. A write takes effect at the clock edge on which the strobe is sampled. Read data returns in a register one cycle after the read strobe. A running channel keeps the period it has started, so a new high-time or divider value only takes effect at the next period boundary and the pin never sees a partial update.

Top module: `pwm_bank`

## Requirements
- R1: There are four independent channels. The control word of channel c sits at byte address c*16. Each channel's pin depends only on its own word.
- R2: Word layout: bit 31 is the run bit, bits 23:16 are the high-time H, and bits 12:0 are the divider field P. A read returns the last value written to these bits, and every other bit reads as 0.
- R3: Read data appears on `rdata` in the cycle after the edge that samples `rd_en`. In a cycle that does not follow a read, `rdata` is 0.
- R4: A write to any address that is not c*16 (for c in 0..3) leaves every control word unchanged. A read from such an address returns 0.
- R5: Writing 0 to a word clears it and stops the channel. A stopped channel holds its pin low and its counters at zero.
- R6: While running, one period lasts 256*(P+1) clock cycles, and the pin is high for H*(P+1) of them.
- R7: With H=0 the pin stays low. With H=255 the pin is low only for the last P+1 cycles of each period.
- R8: After the edge that samples a write setting the run bit on a stopped channel, the pin is low for one cycle. The first period then begins, starting with its high part.
- R9: A change to H or P written while the channel runs does not alter the period in progress. It takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM pin per channel |

## Verification
The assertions assume that the bus strobes are never X after reset and that `addr` and `wdata` are stable in any cycle where a strobe is high. The bench drives every strobe, address and data change 1 ns after a rising edge, which satisfies both conditions. The random passes keep the divider field between 0 and 3, so each measured window stays a few thousand cycles long. Because a measurement always covers whole periods, the expected high count is exactly H*(P+1) for each period in the window, even when it starts at an arbitrary phase.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int WORD_W   = 32;
    localparam int RUN_BIT  = 31;
    localparam int HIGH_LSB = 16;
    localparam int HIGH_W   = 8;
    localparam int DIV_LSB  = 0;
    localparam int DIV_W    = 13;

    typedef struct packed {
        logic              run;
        logic [HIGH_W-1:0] high;
        logic [DIV_W-1:0]  div;
    } chan_word_t;

    function automatic chan_word_t unpack_word(input logic [WORD_W-1:0] w);
        chan_word_t c;
        c.run  = w[RUN_BIT];
        c.high = w[HIGH_LSB +: HIGH_W];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input chan_word_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RUN_BIT]              = c.run;
        w[HIGH_LSB +: HIGH_W]   = c.high;
        w[DIV_LSB +: DIV_W]     = c.div;
        return w;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int STRIDE_LG = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          rdata,
    output chan_word_t [NUM_CH-1:0]    cfg_o
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NUM_W = ADDR_W - STRIDE_LG;

    typedef struct packed {
        chan_word_t [NUM_CH-1:0] cfg;
        logic [WORD_W-1:0]       rdata;
    } regs_state_t;

    regs_state_t s_d, s_q;

    logic [NUM_W-1:0] ch_num;
    logic [CH_W-1:0]  ch_sel;
    logic             hit;

    assign ch_num = addr[ADDR_W-1:STRIDE_LG];
    assign ch_sel = ch_num[CH_W-1:0];
    assign hit    = (addr[STRIDE_LG-1:0] == '0) && (32'(ch_num) < NUM_CH);

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        if (wr_en && hit) begin
            s_d.cfg[ch_sel] = unpack_word(wdata);
        end
        if (rd_en && hit) begin
            s_d.rdata = pack_word(s_q.cfg[ch_sel]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
    assign cfg_o = s_q.cfg;

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_word_t        cfg,
    output logic              pwm,
    output logic [HIGH_W-1:0] phase_o
);

    typedef struct packed {
        logic              run;
        logic [DIV_W-1:0]  tick_cnt;
        logic [HIGH_W-1:0] phase;
        logic [HIGH_W-1:0] high_a;
        logic [DIV_W-1:0]  div_a;
    } chan_state_t;

    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            // Idle: counters parked, shadow follows the control word
            s_d.tick_cnt = '0;
            s_d.phase    = '0;
            s_d.high_a   = cfg.high;
            s_d.div_a    = cfg.div;
            s_d.run      = cfg.run;
        end else if (!cfg.run) begin
            s_d = '0;
        end else if (s_q.tick_cnt == s_q.div_a) begin
            s_d.tick_cnt = '0;
            s_d.phase    = s_q.phase + 1'b1;
            if (s_q.phase == '1) begin
                // Period boundary: pick up the new settings
                s_d.high_a = cfg.high;
                s_d.div_a  = cfg.div;
            end
        end else begin
            s_d.tick_cnt = s_q.tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm     = s_q.run && cfg.run && (s_q.phase < s_q.high_a);
    assign phase_o = s_q.phase;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int STRIDE_LG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_word_t [NUM_CH-1:0]              cfg_w;
    logic [NUM_CH-1:0][HIGH_W-1:0]        phase_w;

    pwm_bank_regs #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .STRIDE_LG (STRIDE_LG)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg_o (cfg_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg_w[c]),
            .pwm     (pwm_out[c]),
            .phase_o (phase_w[c])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 8,
    parameter int STRIDE_LG = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [31:0]                   wdata,
    input logic [31:0]                   rdata,
    input logic [NUM_CH-1:0]             pwm_out,
    input chan_word_t [NUM_CH-1:0]       cfg,
    input logic [NUM_CH-1:0][HIGH_W-1:0] phase
);

    logic legal;
    assign legal = (addr[STRIDE_LG-1:0] == '0) &&
                   ((32'(addr) >> STRIDE_LG) < NUM_CH);

    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    assert_unused_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> $stable(cfg));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && legal && ((32'(addr) >> STRIDE_LG) == c)) |=>
            (pack_word(cfg[c]) == ($past(wdata) & 32'h80FF_1FFF)));

        assert_stopped_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[c].run |-> !pwm_out[c]);

        assert_stopped_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cfg[c].run) |-> (phase[c] == '0));

        assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (phase[c] == $past(phase[c])) ||
            (phase[c] == $past(phase[c]) + 8'd1) ||
            (phase[c] == '0));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .STRIDE_LG (STRIDE_LG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out),
    .cfg     (cfg_w),
    .phase   (phase_w)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwm_bank i_pwm_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    function automatic logic [31:0] visible(input logic [31:0] w);
        return w & 32'h80FF_1FFF;
    endfunction

    function automatic logic [31:0] make_word(input bit run, input int high, input int div);
        return {run, 7'd0, 8'(high), 3'd0, 13'(div)};
    endfunction

    function automatic int expect_high(input int high, input int div, input int periods);
        return high * (div + 1) * periods;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Counts high samples of one channel over n consecutive cycles
    task automatic count_high(input int ch, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (pwm_out[ch]) cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int cnt;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        check("R5 reset pins", 32'(pwm_out), 32'h0);
        for (int c = 0; c < 4; c++) begin
            bus_read(8'(c * 16), rd);
            check("R2 reset word", rd, 32'h0);
        end
        @(posedge clk); #1;
        check("R3 rdata idle", rdata, 32'h0);

        // Masking of unused bits
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h20, rd);
        check("R2 all-ones readback", rd, 32'h80FF_1FFF);
        bus_write(8'h20, 32'h0);
        bus_read(8'h20, rd);
        check("R5 zero clears", rd, 32'h0);
        @(posedge clk); #1;
        check("R5 pin low after clear", 32'(pwm_out[2]), 32'h0);

        // Unused offsets
        bus_write(8'h30, 32'h0012_0034);
        bus_write(8'h34, 32'h8055_0001);
        bus_write(8'h40, 32'h8066_0002);
        bus_write(8'h08, 32'h8077_0003);
        bus_read(8'h30, rd);
        check("R4 ch3 untouched", rd, 32'h0012_0034);
        for (int c = 0; c < 3; c++) begin
            bus_read(8'(c * 16), rd);
            check("R4 other words untouched", rd, 32'h0);
        end
        bus_read(8'h34, rd);
        check("R4 unused read zero", rd, 32'h0);
        bus_read(8'h40, rd);
        check("R4 out-of-range read zero", rd, 32'h0);
        check("R4 pins stay low", 32'(pwm_out), 32'h0);
        bus_write(8'h30, 32'h0);

        // Directed: duty 0 and duty 255
        bus_write(8'h00, make_word(1'b1, 0, 1));
        count_high(0, 1024, cnt);
        check("R7 zero high-time", 32'(cnt), 32'h0);
        bus_write(8'h00, 32'h0);
        bus_write(8'h00, make_word(1'b1, 255, 1));
        check("R8 low right after enable", 32'(pwm_out[0]), 32'h0);
        count_high(0, 510, cnt);
        check("R7 full high part", 32'(cnt), 32'd510);
        count_high(0, 2, cnt);
        check("R7 low tail", 32'(cnt), 32'h0);
        @(posedge clk); #1;
        check("R7 next period high", 32'(pwm_out[0]), 32'h1);
        bus_write(8'h00, 32'h0);
        @(posedge clk); #1;
        check("R5 disable drops pin", 32'(pwm_out[0]), 32'h0);

        // Random configurations
        for (int it = 0; it < 8; it++) begin
            int ch, hi, dv;
            logic [31:0] w;
            ch = int'($urandom_range(3, 0));
            hi = int'($urandom_range(255, 0));
            dv = int'($urandom_range(3, 0));
            if (it == 0) hi = 1;
            w = {1'b1, 7'($urandom), 8'(hi), 3'($urandom), 13'(dv)};
            bus_write(8'(ch * 16), w);
            check("R8 low first cycle", 32'(pwm_out[ch]), 32'h0);
            @(posedge clk); #1;
            check("R8 period starts high", 32'(pwm_out[ch]), (hi > 0) ? 32'h1 : 32'h0);
            count_high(ch, 2 * 256 * (dv + 1) - 1, cnt);
            check("R6 high count two periods",
                  32'(cnt + int'(hi > 0)), 32'(expect_high(hi, dv, 2)));
            bus_read(8'(ch * 16), rd);
            check("R2 random readback", rd, visible(w));
            bus_write(8'(ch * 16), 32'h0);
            @(posedge clk); #1;
            check("R5 random disable", 32'(pwm_out), 32'h0);
        end

        // Update inside a running period
        bus_write(8'h10, make_word(1'b1, 40, 1));
        cnt = 0;
        for (int i = 0; i < 512; i++) begin
            @(posedge clk); #1;
            if (pwm_out[1]) cnt++;
            if (i == 100) begin
                wr_en = 1'b1; addr = 8'h10; wdata = make_word(1'b1, 200, 1);
            end else begin
                wr_en = 1'b0;
            end
        end
        check("R9 current period keeps old", 32'(cnt), 32'(expect_high(40, 1, 1)));
        count_high(1, 512, cnt);
        check("R9 next period uses new", 32'(cnt), 32'(expect_high(200, 1, 1)));
        bus_write(8'h10, 32'h0);

        // Two channels at once
        bus_write(8'h20, make_word(1'b1, 128, 1));
        bus_write(8'h00, make_word(1'b1, 64, 0));
        @(posedge clk); #1;
        begin
            int c0, c2;
            c0 = 0; c2 = 0;
            for (int i = 0; i < 512; i++) begin
                @(posedge clk); #1;
                if (pwm_out[0]) c0++;
                if (pwm_out[2]) c2++;
            end
            check("R1 ch0 independent", 32'(c0), 32'(expect_high(64, 0, 2)));
            check("R1 ch2 independent", 32'(c2), 32'(expect_high(128, 1, 1)));
            check("R1 idle channels low", 32'(pwm_out[1] | pwm_out[3]), 32'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule